// File: doc/BRIEF.md
# Clock Fanout Mode Controller

This block produces the control signals for a nine-output clock fanout buffer: one group of four outputs (bank A), a second group of four (bank B) and a single feedback output. Two select pins choose among four operating modes. The block turns the pin code into per-bank output enables, a source choice between the PLL and a direct reference bypass, and a PLL enable. It runs entirely on a free-running timebase clock. The reference clock is treated only as a sampled signal.

Two supervisory functions override the pin decode. An activity detector counts reference rising edges over a fixed timebase window, and declares the reference stopped when too few edges arrive. While the reference is stopped, every output is disabled and the PLL is turned off. A lock-wait sequencer keeps all PLL-sourced outputs disabled for a fixed number of cycles whenever the PLL has just been turned on. This happens after power-up, after the reference restarts, and when the mode leaves bypass. Bypass mode needs no wait.

Top module: `fanout_mode_ctl`

## Requirements
- R1: With select code {sel_hi,sel_lo}=11 in steady operation, bank A, bank B and the feedback output are enabled, pll_en=1 and bypass_sel=0.
- R2: With select code 01 in steady operation, bank A and the feedback output are enabled, bank B is disabled, and pll_en=1 with bypass_sel=0.
- R3: With select code 00 in steady operation, both banks are disabled, the feedback output stays enabled, and pll_en=1 with bypass_sel=0.
- R4: Select code 10 is bypass. While the reference is active, all three enables are 1, bypass_sel=1 and pll_en=0, with no lock wait after entry.
- R5: While the reference is judged stopped, every enable, pll_en and bypass_sel are 0, whatever the select code.
- R6: The reference is judged at the end of each WINDOW-cycle timebase window. It is active when at least MIN_EDGES rising edges were seen in that window, and stopped otherwise. It is judged stopped from reset until the first window ends.
- R7: When the PLL is turned on, pll_en=1 with all enables 0 for exactly LOCK_CYCLES cycles before the decoded PLL-mode enables appear. The PLL is turned on by leaving the stopped state into a PLL mode, or by moving from bypass to a PLL mode.
- R8: Changing between the PLL modes 11, 01 and 00 does not restart the lock wait.
- R9: Both select pins pass through two-flop synchronizers. Enables follow a select change on the third timebase clock edge after it.
- R10: During reset all outputs are 0, and the select synchronizers hold code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Reference clock, sampled as asynchronous data |
| sel_hi | input | 1 | Upper select pin, asynchronous |
| sel_lo | input | 1 | Lower select pin, asynchronous |
| bank_a_oe | output | 1 | Enable for the four bank A outputs |
| bank_b_oe | output | 1 | Enable for the four bank B outputs |
| fb_oe | output | 1 | Enable for the feedback output |
| bypass_sel | output | 1 | 1 = outputs sourced from reference, 0 = from PLL |
| pll_en | output | 1 | PLL run enable |

## Verification
A select change reaches the enables on the third clock edge after it: two synchronizer stages and then the output register. The bench therefore samples two falling edges after the drive, where it expects the old value, and three falling edges after, where it expects the new one. The lock wait ends exactly LOCK_CYCLES edges after that point, so checks sit at LOCK_CYCLES+2 falling edges (still waiting) and LOCK_CYCLES+3 (released). Activity changes are only resolved at window boundaries, and the phase of the window is not visible. Stop and restart checks therefore wait at least two full windows plus the synchronizer delay before sampling, and then sample inside the lock wait or well after it ends.

// File: rtl/fanout_ctl_pkg.sv
package fanout_ctl_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_LOCK = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    localparam logic [1:0] MODE_NONE   = 2'b00;
    localparam logic [1:0] MODE_A_ONLY = 2'b01;
    localparam logic [1:0] MODE_BYPASS = 2'b10;
    localparam logic [1:0] MODE_ALL    = 2'b11;

    typedef struct packed {
        logic oe_a;
        logic oe_b;
        logic oe_fb;
        logic bypass;
        logic pll_on;
    } ctl_out_t;

endpackage

// File: rtl/sel_sync.sv
module sel_sync #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ref_activity.sv
module ref_activity #(
    parameter int WINDOW    = 256,
    parameter int MIN_EDGES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic active_o
);
    localparam int WIN_W  = $clog2(WINDOW);
    localparam int EDGE_W = $clog2(MIN_EDGES + 1);

    typedef struct packed {
        logic              prev;
        logic [WIN_W-1:0]  win;
        logic [EDGE_W-1:0] edges;
        logic              active;
    } act_regs_t;

    act_regs_t act_d, act_q;
    logic ref_s;
    logic rise;
    logic [EDGE_W-1:0] edges_inc;

    sel_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_ref_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ref_i),
        .sync_o  (ref_s)
    );

    always_comb begin
        act_d      = act_q;
        act_d.prev = ref_s;
        rise       = ref_s & ~act_q.prev;
        // saturate so the counter never wraps below the threshold
        if (act_q.edges == EDGE_W'(MIN_EDGES)) edges_inc = act_q.edges;
        else                                   edges_inc = act_q.edges + EDGE_W'(rise);
        if (act_q.win == WIN_W'(WINDOW - 1)) begin
            act_d.active = (edges_inc == EDGE_W'(MIN_EDGES));
            act_d.win    = '0;
            act_d.edges  = '0;
        end else begin
            act_d.win    = act_q.win + 1'b1;
            act_d.edges  = edges_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign active_o = act_q.active;
endmodule

// File: rtl/mode_decode.sv
module mode_decode
    import fanout_ctl_pkg::*;
(
    input  seq_state_e state_i,
    input  logic [1:0] mode_i,
    output ctl_out_t   ctl_o
);
    always_comb begin
        ctl_o = '0;
        unique case (state_i)
            SEQ_LOCK: ctl_o.pll_on = 1'b1;
            SEQ_RUN: begin
                if (mode_i == MODE_BYPASS) begin
                    ctl_o.oe_a   = 1'b1;
                    ctl_o.oe_b   = 1'b1;
                    ctl_o.oe_fb  = 1'b1;
                    ctl_o.bypass = 1'b1;
                end else begin
                    ctl_o.pll_on = 1'b1;
                    ctl_o.oe_fb  = 1'b1;
                    ctl_o.oe_a   = (mode_i != MODE_NONE);
                    ctl_o.oe_b   = (mode_i == MODE_ALL);
                end
            end
            default: ctl_o = '0;
        endcase
    end
endmodule

// File: rtl/fanout_mode_ctl.sv
module fanout_mode_ctl
    import fanout_ctl_pkg::*;
#(
    parameter int WINDOW      = 256,
    parameter int MIN_EDGES   = 6,
    parameter int LOCK_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic sel_hi,
    input  logic sel_lo,
    output logic bank_a_oe,
    output logic bank_b_oe,
    output logic fb_oe,
    output logic bypass_sel,
    output logic pll_en
);
    localparam int LCK_W = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;

    typedef struct packed {
        seq_state_e       st;
        logic [LCK_W-1:0] cnt;
        ctl_out_t         out;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic [1:0] mode_s;
    logic       ref_active;
    logic       is_byp;
    ctl_out_t   out_next;

    sel_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sel_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sel_hi, sel_lo}),
        .sync_o  (mode_s)
    );

    ref_activity #(.WINDOW(WINDOW), .MIN_EDGES(MIN_EDGES)) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_i    (ref_clk),
        .active_o (ref_active)
    );

    mode_decode u_dec (
        .state_i (seq_d.st),
        .mode_i  (mode_s),
        .ctl_o   (out_next)
    );

    assign is_byp = (mode_s == MODE_BYPASS);

    always_comb begin
        seq_d.st  = seq_q.st;
        seq_d.cnt = seq_q.cnt;
        unique case (seq_q.st)
            SEQ_OFF: begin
                if (ref_active) begin
                    seq_d.cnt = '0;
                    seq_d.st  = is_byp ? SEQ_RUN : SEQ_LOCK;
                end
            end
            SEQ_LOCK: begin
                if (!ref_active)                            seq_d.st = SEQ_OFF;
                else if (is_byp)                            seq_d.st = SEQ_RUN;
                else if (seq_q.cnt == LCK_W'(LOCK_CYCLES-1)) seq_d.st = SEQ_RUN;
                else                                        seq_d.cnt = seq_q.cnt + 1'b1;
            end
            SEQ_RUN: begin
                if (!ref_active) begin
                    seq_d.st = SEQ_OFF;
                end else if (seq_q.out.bypass && !is_byp) begin
                    // leaving bypass turns the PLL on: wait for lock again
                    seq_d.st  = SEQ_LOCK;
                    seq_d.cnt = '0;
                end
            end
            default: seq_d.st = SEQ_OFF;
        endcase
        seq_d.out = out_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st  <= SEQ_OFF;
            seq_q.cnt <= '0;
            seq_q.out <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bank_a_oe  = seq_q.out.oe_a;
    assign bank_b_oe  = seq_q.out.oe_b;
    assign fb_oe      = seq_q.out.oe_fb;
    assign bypass_sel = seq_q.out.bypass;
    assign pll_en     = seq_q.out.pll_on;
endmodule

// File: rtl/fanout_mode_ctl_chk.sv
module fanout_mode_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic bank_a_oe,
    input logic bank_b_oe,
    input logic fb_oe,
    input logic bypass_sel,
    input logic pll_en
);
    // R1 R2 R3: bank B is never enabled without bank A
    assert_b_implies_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_b_oe |-> bank_a_oe);

    // R3: any bank enabled means the feedback output is enabled
    assert_bank_needs_fb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_a_oe || bank_b_oe) |-> fb_oe);

    // R4: bypass drives everything with the PLL off
    assert_bypass_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_sel |-> (!pll_en && bank_a_oe && bank_b_oe && fb_oe));

    // R5: an enabled output without bypass needs the PLL running
    assert_pll_src_needs_pll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_oe && !bypass_sel) |-> pll_en);

    // R7: the PLL starts with every output held off
    assert_lock_start_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> (!bank_a_oe && !bank_b_oe && !fb_oe));

    // R7: PLL-sourced feedback only turns on after the PLL was already on
    assert_fb_after_pll_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fb_oe) && !bypass_sel) |-> $past(pll_en));
endmodule

bind fanout_mode_ctl fanout_mode_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_a_oe  (bank_a_oe),
    .bank_b_oe  (bank_b_oe),
    .fb_oe      (fb_oe),
    .bypass_sel (bypass_sel),
    .pll_en     (pll_en)
);

// File: tb/fanout_mode_ctl_tb.sv
module fanout_mode_ctl_tb;
    localparam int WINDOW    = 64;
    localparam int MIN_EDGES = 4;
    localparam int LOCK      = 300;

    // output vector {bank_a_oe, bank_b_oe, fb_oe, bypass_sel, pll_en}
    localparam logic [4:0] V_OFF  = 5'b00000;
    localparam logic [4:0] V_LOCK = 5'b00001;
    localparam logic [4:0] V_ALL  = 5'b11101;
    localparam logic [4:0] V_A    = 5'b10101;
    localparam logic [4:0] V_NONE = 5'b00101;
    localparam logic [4:0] V_BYP  = 5'b11110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic sel_hi = 1'b1;
    logic sel_lo = 1'b1;
    logic bank_a_oe, bank_b_oe, fb_oe, bypass_sel, pll_en;
    int   ref_half = 4;
    int   ref_cnt = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    fanout_mode_ctl #(.WINDOW(WINDOW), .MIN_EDGES(MIN_EDGES), .LOCK_CYCLES(LOCK)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .sel_hi(sel_hi), .sel_lo(sel_lo),
        .bank_a_oe(bank_a_oe), .bank_b_oe(bank_b_oe), .fb_oe(fb_oe),
        .bypass_sel(bypass_sel), .pll_en(pll_en)
    );

    // reference generator: ref_half = timebase cycles per half period, 0 holds level
    always @(negedge clk) begin
        if (ref_half != 0) begin
            if (ref_cnt >= ref_half - 1) begin
                ref_clk <= ~ref_clk;
                ref_cnt <= 0;
            end else begin
                ref_cnt <= ref_cnt + 1;
            end
        end
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [4:0] expv);
        logic [4:0] act;
        act = {bank_a_oe, bank_b_oe, fb_oe, bypass_sel, pll_en};
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        {sel_hi, sel_lo} = m;
    endtask

    task automatic t_reset();
        wait_neg(5);
        chk("R10 reset", V_OFF);
        @(negedge clk) rst_n = 1'b1;
        wait_neg(20);
        chk("R6 stopped before first window", V_OFF);
    endtask

    task automatic t_bringup();
        wait_neg(130);
        chk("R7 lock wait after power-up", V_LOCK);
        wait_neg(LOCK + 50);
        chk("R1 mode 11 steady", V_ALL);
    endtask

    task automatic t_pll_modes();
        set_mode(2'b01);
        wait_neg(2);
        chk("R9 no change after two edges", V_ALL);
        wait_neg(1);
        chk("R2 mode 01 / R8 no relock", V_A);
        set_mode(2'b00);
        wait_neg(3);
        chk("R3 mode 00", V_NONE);
        set_mode(2'b11);
        wait_neg(3);
        chk("R8 back to 11 without lock wait", V_ALL);
    endtask

    task automatic t_bypass();
        set_mode(2'b10);
        wait_neg(3);
        chk("R4 bypass immediate", V_BYP);
        set_mode(2'b11);
        wait_neg(3);
        chk("R7 lock wait on leaving bypass", V_LOCK);
        wait_neg(LOCK - 1);
        chk("R7 still waiting at LOCK_CYCLES+2", V_LOCK);
        wait_neg(1);
        chk("R7 released at LOCK_CYCLES+3", V_ALL);
    endtask

    task automatic t_threshold();
        ref_half = 8;
        wait_neg(3 * WINDOW);
        chk("R6 exactly MIN_EDGES per window stays active", V_ALL);
        ref_half = 20;
        wait_neg(3 * WINDOW);
        chk("R6 too few edges is stopped", V_OFF);
    endtask

    task automatic t_stop_restart();
        ref_half = 4;
        wait_neg(2 * WINDOW + 20);
        chk("R7 restart enters lock wait", V_LOCK);
        wait_neg(LOCK + WINDOW);
        chk("R1 restored after restart", V_ALL);
        ref_half = 0;
        wait_neg(3 * WINDOW);
        chk("R5 static reference stops all", V_OFF);
        set_mode(2'b10);
        wait_neg(10);
        chk("R5 select ignored while stopped", V_OFF);
        ref_half = 4;
        wait_neg(2 * WINDOW + 20);
        chk("R4 bypass restart needs no lock", V_BYP);
    endtask

    initial begin
        t_reset();
        t_bringup();
        t_pll_modes();
        t_bypass();
        t_threshold();
        t_stop_restart();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule